// File: doc/BRIEF.md
# CPU Address Decoder with Boot-ROM Overlay

This block sits between an 8-bit CPU and the memories of a small system built around a flat 64 KB RAM. It looks at each 16-bit bus access and steers it to one of several targets:

- main RAM;
- a one-page window into a 64 KB video RAM;
- a page of peripheral memories (sprites, sound, palette);
- a small register file of hardware controls;
- a 512-byte boot ROM that covers the top of memory for reads only.

The register file holds the video page number and the control byte whose bit 3 maps the boot ROM in or out.

The CPU bus is synchronous. Every clock cycle is one access: a write when the write strobe is high, and a read otherwise. Every target returns read data one cycle after the access. The decoder remembers which target it selected and uses that to multiplex the returned byte. After reset the ROM overlay is active, so the CPU fetches its reset vector from ROM. Boot code copies the operating system into RAM, including the top 512 bytes, which writes always reach. It then clears the overlay bit and runs entirely from RAM.

Top module: `memmap_decoder`

## Requirements
- R1: After the synchronous active-low reset, `cpu_rdata` is 0x00, the control register at $0602 reads 0x08 (overlay on), the page register at $0605 reads 0x00, and a read of $FFFC returns ROM data.
- R2: Accesses to $0000-$03FF and $0618-$FDFF assert `ram_en` with `ram_addr` equal to the CPU address, and `ram_we` and `ram_wdata` follow the CPU.
- R3: Accesses to $0400-$04FF assert `vram_en` with `vram_addr` = {page register, CPU address[7:0]}.
- R4: A write to $0605 loads the 8-bit page register. Video accesses from the next cycle on use the new page, and reading $0605 returns it.
- R5: Accesses to $0500-$05FF assert `per_en` with `per_addr` = CPU address[7:0].
- R6: Accesses to $0600-$0617 enable no external port. Offsets other than $0602 and $0605 read 0x00, and writes to them change no state.
- R7: While bit 3 of $0602 is set, reads of $FE00-$FFFF assert `rom_en` with `rom_addr` = CPU address[8:0], and RAM is not enabled.
- R8: Writes to $FE00-$FFFF always assert `ram_en` and `ram_we`, whatever the overlay bit.
- R9: $0602 is an 8-bit read/write register. While its bit 3 is clear, reads of $FE00-$FFFF go to RAM, and setting the bit again restores ROM reads.
- R10: `cpu_rdata` in the cycle after a read carries that read's data from the selected target. In the cycle after a write it is 0x00.
- R11: At most one of `ram_en`, `vram_en`, `per_en`, `rom_en` is high in any cycle. Exactly one is high for every address outside $0600-$0617.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe; low means read |
| cpu_rdata | output | 8 | Read data, one cycle after the access |
| ram_en | output | 1 | Main RAM select |
| ram_we | output | 1 | Main RAM write enable |
| ram_addr | output | 16 | Main RAM address |
| ram_wdata | output | 8 | Main RAM write data |
| ram_rdata | input | 8 | Main RAM read data (registered in RAM) |
| vram_en | output | 1 | Video RAM select |
| vram_we | output | 1 | Video RAM write enable |
| vram_addr | output | 16 | Video RAM address {page, offset} |
| vram_wdata | output | 8 | Video RAM write data |
| vram_rdata | input | 8 | Video RAM read data |
| per_en | output | 1 | Peripheral page select |
| per_we | output | 1 | Peripheral page write enable |
| per_addr | output | 8 | Offset within peripheral page |
| per_wdata | output | 8 | Peripheral write data |
| per_rdata | input | 8 | Peripheral read data |
| rom_en | output | 1 | Boot ROM read select |
| rom_addr | output | 9 | Boot ROM address |
| rom_rdata | input | 8 | Boot ROM read data |

## Verification
The bench targets the edges of each region: $03FF/$0400, $04FF/$0500, $05FF/$0600, $0617/$0618 and $FDFF/$FE00. A decoder with an off-by-one there would send a byte to the wrong memory. It writes the page register and makes a video access in the very next cycle. A page register that is bypassed, or that updates a cycle late, shows up as the wrong `vram_addr`. It writes the top 512 bytes with the overlay both on and off, and toggles bit 3 between reads. A design that blocks those writes, or that decodes the overlay inverted, returns ROM bytes where RAM is expected. Reads that follow writes and accesses that change target from one cycle to the next expose a read multiplexer steered by the current address instead of the registered one.

// File: rtl/memmap_pkg.sv
// Shared constants and the target type for the address decoder.
// Assumes a 16-bit CPU address space and 8-bit data.
package memmap_pkg;

    typedef enum logic [2:0] {
        TGT_NONE   = 3'd0,
        TGT_RAM    = 3'd1,
        TGT_VRAM   = 3'd2,
        TGT_PERIPH = 3'd3,
        TGT_IO     = 3'd4,
        TGT_ROM    = 3'd5
    } target_e;

    localparam int          CPU_AW       = 16;
    localparam logic [7:0]  VRAM_PAGE    = 8'h04;
    localparam logic [7:0]  PERIPH_PAGE  = 8'h05;
    localparam int          IO_BASE      = 32'h0600;
    localparam int          REG_CTRL_OFS = 2;
    localparam int          REG_PAGE_OFS = 5;
    localparam int          CTRL_OVL_BIT = 3;
    localparam logic [7:0]  CTRL_RESET   = 8'h08;

endpackage

// File: rtl/mm_addr_decode.sv
// Combinational region decode of one CPU access.
// Assumes the I/O block starts on a boundary aligned to its size and the
// boot ROM is a power-of-two block ending at the top of the address space.
module mm_addr_decode
    import memmap_pkg::*;
#(
    parameter int ROM_AW   = 9,
    parameter int IO_COUNT = 24
) (
    input  logic [CPU_AW-1:0] addr,
    input  logic              we,
    input  logic              ovl_en,
    output target_e           tgt
);
    localparam logic [CPU_AW-1:0] ROM_BASE = CPU_AW'((32'h10000) - (32'd1 << ROM_AW));
    localparam logic [CPU_AW-1:0] IO_LO    = CPU_AW'(IO_BASE);
    localparam logic [CPU_AW-1:0] IO_HI    = CPU_AW'(IO_BASE + IO_COUNT);

    logic in_io;
    logic in_rom;

    // Region membership for the ranges that are not whole pages.
    always_comb begin
        in_io  = (addr >= IO_LO) && (addr < IO_HI);
        in_rom = (addr >= ROM_BASE);
    end

    // Priority pick of the target; the ROM covers reads only.
    always_comb begin
        tgt = TGT_RAM;
        if (addr[CPU_AW-1:8] == VRAM_PAGE) begin
            tgt = TGT_VRAM;
        end else if (addr[CPU_AW-1:8] == PERIPH_PAGE) begin
            tgt = TGT_PERIPH;
        end else if (in_io) begin
            tgt = TGT_IO;
        end else if (in_rom && ovl_en && !we) begin
            tgt = TGT_ROM;
        end
    end

endmodule

// File: rtl/mm_io_regs.sv
// Hardware control register file: the control byte (bit 3 = boot overlay)
// and the video page register. Other offsets read zero and drop writes.
// Read data is registered: it appears one cycle after the access.
module mm_io_regs
    import memmap_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int IO_COUNT = 24,
    localparam int IO_AW   = $clog2(IO_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic [IO_AW-1:0]  ofs,
    input  logic [DATA_W-1:0] wdata,
    output logic              ovl_en,
    output logic [DATA_W-1:0] page_q,
    output logic [DATA_W-1:0] rd_q
);
    localparam logic [IO_AW-1:0] OFS_CTRL = IO_AW'(REG_CTRL_OFS);
    localparam logic [IO_AW-1:0] OFS_PAGE = IO_AW'(REG_PAGE_OFS);

    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] rd_d;
    logic              wr_ctrl;
    logic              wr_page;

    // Write strobes for the two implemented registers.
    always_comb begin
        wr_ctrl = sel && we && (ofs == OFS_CTRL);
        wr_page = sel && we && (ofs == OFS_PAGE);
    end

    // Read lookup; unimplemented offsets return zero.
    always_comb begin
        rd_d = '0;
        if (sel && !we) begin
            if (ofs == OFS_CTRL) rd_d = ctrl_q;
            else if (ofs == OFS_PAGE) rd_d = page_q;
        end
    end

    // Register state and registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= DATA_W'(CTRL_RESET);
            page_q <= '0;
            rd_q   <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata;
            if (wr_page) page_q <= wdata;
            rd_q <= rd_d;
        end
    end

    assign ovl_en = ctrl_q[CTRL_OVL_BIT];

    // R4: a page write is visible on the next cycle.
    p_page_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && we && ofs == OFS_PAGE) |=> (page_q == $past(wdata)));

    // R9: the overlay bit changes only through a write to the control register.
    p_ovl_by_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ovl_en) |-> $past(sel && we && ofs == OFS_CTRL));

    // R6: writes to unused offsets leave the page register alone.
    p_unused_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && we && ofs != OFS_PAGE) |=> $stable(page_q));

endmodule

// File: rtl/mm_rdata_mux.sv
// Remembers which target the last access read and multiplexes the
// one-cycle-late data of that target onto the CPU read bus. A write or a
// reset leaves nothing selected, so the bus reads zero.
module mm_rdata_mux
    import memmap_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  target_e           tgt,
    input  logic              we,
    input  logic [DATA_W-1:0] ram_rd,
    input  logic [DATA_W-1:0] vram_rd,
    input  logic [DATA_W-1:0] per_rd,
    input  logic [DATA_W-1:0] rom_rd,
    input  logic [DATA_W-1:0] io_rd,
    output logic [DATA_W-1:0] rdata
);
    target_e sel_q;

    // Track the target of the previous read.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= TGT_NONE;
        else        sel_q <= we ? TGT_NONE : tgt;
    end

    // Steer the returned byte.
    always_comb begin
        unique case (sel_q)
            TGT_RAM:    rdata = ram_rd;
            TGT_VRAM:   rdata = vram_rd;
            TGT_PERIPH: rdata = per_rd;
            TGT_ROM:    rdata = rom_rd;
            TGT_IO:     rdata = io_rd;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/memmap_decoder.sv
// Top of the CPU address decoder. Every cycle is one access. Strobes to the
// memories are combinational from the CPU bus; every memory is assumed to
// return read data one cycle later. The I/O register file lives here.
module memmap_decoder
    import memmap_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ROM_AW   = 9,
    parameter int IO_COUNT = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_we,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              ram_en,
    output logic              ram_we,
    output logic [15:0]       ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              vram_en,
    output logic              vram_we,
    output logic [15:0]       vram_addr,
    output logic [DATA_W-1:0] vram_wdata,
    input  logic [DATA_W-1:0] vram_rdata,
    output logic              per_en,
    output logic              per_we,
    output logic [7:0]        per_addr,
    output logic [DATA_W-1:0] per_wdata,
    input  logic [DATA_W-1:0] per_rdata,
    output logic              rom_en,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [DATA_W-1:0] rom_rdata
);
    localparam int IO_AW = $clog2(IO_COUNT);
    localparam logic [15:0] ROM_BASE = 16'((32'h10000) - (32'd1 << ROM_AW));

    target_e           tgt;
    logic              ovl_en;
    logic [DATA_W-1:0] page_q;
    logic [DATA_W-1:0] io_rd;

    mm_addr_decode #(.ROM_AW(ROM_AW), .IO_COUNT(IO_COUNT)) u_dec (
        .addr   (cpu_addr),
        .we     (cpu_we),
        .ovl_en (ovl_en),
        .tgt    (tgt)
    );

    mm_io_regs #(.DATA_W(DATA_W), .IO_COUNT(IO_COUNT)) u_io (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (tgt == TGT_IO),
        .we     (cpu_we),
        .ofs    (cpu_addr[IO_AW-1:0]),
        .wdata  (cpu_wdata),
        .ovl_en (ovl_en),
        .page_q (page_q),
        .rd_q   (io_rd)
    );

    mm_rdata_mux #(.DATA_W(DATA_W)) u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .tgt     (tgt),
        .we      (cpu_we),
        .ram_rd  (ram_rdata),
        .vram_rd (vram_rdata),
        .per_rd  (per_rdata),
        .rom_rd  (rom_rdata),
        .io_rd   (io_rd),
        .rdata   (cpu_rdata)
    );

    // Port strobes and addresses for each external target.
    always_comb begin
        ram_en     = (tgt == TGT_RAM);
        ram_we     = ram_en && cpu_we;
        ram_addr   = cpu_addr;
        ram_wdata  = cpu_wdata;
        vram_en    = (tgt == TGT_VRAM);
        vram_we    = vram_en && cpu_we;
        vram_addr  = {page_q, cpu_addr[7:0]};
        vram_wdata = cpu_wdata;
        per_en     = (tgt == TGT_PERIPH);
        per_we     = per_en && cpu_we;
        per_addr   = cpu_addr[7:0];
        per_wdata  = cpu_wdata;
        rom_en     = (tgt == TGT_ROM);
        rom_addr   = cpu_addr[ROM_AW-1:0];
    end

    // R7: the ROM is never selected by a write.
    p_rom_read_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rom_en |-> !cpu_we);

    // R8: writes at the top always land in RAM.
    p_top_write_ram_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr >= ROM_BASE) |-> (ram_en && ram_we));

    // R11: never two targets at once.
    p_one_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_en, vram_en, per_en, rom_en}));

    // R10: the cycle after a write reads zero.
    p_zero_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_we |=> (cpu_rdata == '0));

endmodule

// File: tb/memmap_decoder_bench.sv
`timescale 1ns/1ps
module memmap_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        ram_en, ram_we, vram_en, vram_we, per_en, per_we, rom_en;
    logic [15:0] ram_addr, vram_addr;
    logic [7:0]  ram_wdata, vram_wdata, per_addr, per_wdata;
    logic [8:0]  rom_addr;
    logic [7:0]  ram_q = '0, vram_q = '0, per_q = '0, rom_q = '0;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [7:0] m_ctrl = 8'h08;
    logic [7:0] m_page = 8'h00;

    always #10 clk = ~clk;

    memmap_decoder u_memmap_decoder (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .cpu_rdata(cpu_rdata),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_q),
        .vram_en(vram_en), .vram_we(vram_we), .vram_addr(vram_addr),
        .vram_wdata(vram_wdata), .vram_rdata(vram_q),
        .per_en(per_en), .per_we(per_we), .per_addr(per_addr),
        .per_wdata(per_wdata), .per_rdata(per_q),
        .rom_en(rom_en), .rom_addr(rom_addr), .rom_rdata(rom_q)
    );

    // Memory models: each returns a distinct function of its address.
    function automatic logic [7:0] f_ram(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction
    function automatic logic [7:0] f_vram(input logic [15:0] a);
        return (a[7:0] + (a[15:8] * 8'd3)) ^ 8'hA5;
    endfunction
    function automatic logic [7:0] f_per(input logic [7:0] a);
        return (~a) + 8'h11;
    endfunction
    function automatic logic [7:0] f_rom(input logic [8:0] a);
        return a[7:0] ^ (a[8] ? 8'hC3 : 8'h3C);
    endfunction

    always_ff @(posedge clk) begin
        ram_q  <= f_ram(ram_addr);
        vram_q <= f_vram(vram_addr);
        per_q  <= f_per(per_addr);
        rom_q  <= f_rom(rom_addr);
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus access: check strobes mid-cycle, data after the edge.
    task automatic access(input logic [15:0] a, input bit w, input logic [7:0] d);
        int    t;     // 1 ram 2 vram 3 per 4 io 5 rom
        string tag;
        logic [7:0] exp_rd;
        logic [15:0] va;
        cpu_addr = a; cpu_we = w; cpu_wdata = d;
        va = {m_page, a[7:0]};
        if (a[15:8] == 8'h04) begin t = 2; tag = "R3"; end
        else if (a[15:8] == 8'h05) begin t = 3; tag = "R5"; end
        else if (a >= 16'h0600 && a < 16'h0618) begin
            t = 4;
            tag = (a == 16'h0605) ? "R4" : (a == 16'h0602) ? "R9" : "R6";
        end else if (a >= 16'hFE00 && !w && m_ctrl[3]) begin t = 5; tag = "R7"; end
        else begin
            t = 1;
            tag = (a >= 16'hFE00) ? (w ? "R8" : "R9") : "R2";
        end
        #2;
        chk({ram_en, vram_en, per_en, rom_en} ==
            {t == 1, t == 2, t == 3, t == 5}, {tag, " R11 enables"},
            {28'h0, ram_en, vram_en, per_en, rom_en},
            {28'h0, t == 1, t == 2, t == 3, t == 5});
        case (t)
            1: chk(ram_addr == a && ram_we == w && (!w || ram_wdata == d),
                   tag, {ram_we, ram_addr}, {w, a});
            2: chk(vram_addr == va && vram_we == w, tag, {vram_we, vram_addr}, {w, va});
            3: chk(per_addr == a[7:0] && per_we == w, tag, {per_we, per_addr}, {w, a[7:0]});
            5: chk(rom_addr == a[8:0], tag, rom_addr, a[8:0]);
            default: ;
        endcase
        if (w) exp_rd = 8'h00;
        else case (t)
            1: exp_rd = f_ram(a);
            2: exp_rd = f_vram(va);
            3: exp_rd = f_per(a[7:0]);
            5: exp_rd = f_rom(a[8:0]);
            default: exp_rd = (a == 16'h0602) ? m_ctrl : (a == 16'h0605) ? m_page : 8'h00;
        endcase
        @(posedge clk);
        #2;
        chk(cpu_rdata == exp_rd, {tag, " R10 rdata"}, cpu_rdata, exp_rd);
        if (w && a == 16'h0602) m_ctrl = d;
        if (w && a == 16'h0605) m_page = d;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20211));
        repeat (4) @(posedge clk);
        #2;
        chk(cpu_rdata == 8'h00, "R1 rdata in reset", cpu_rdata, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        access(16'h0602, 0, 0);
        access(16'h0605, 0, 0);
        access(16'hFFFC, 0, 0);
        // region edges (R2 R3 R5 R6 R7)
        access(16'h03FF, 0, 0); access(16'h0400, 0, 0); access(16'h04FF, 0, 0);
        access(16'h0500, 0, 0); access(16'h05FF, 0, 0); access(16'h0600, 0, 0);
        access(16'h0617, 0, 0); access(16'h0618, 0, 0); access(16'hFDFF, 0, 0);
        access(16'hFE00, 0, 0); access(16'hFFFF, 0, 0);
        // R4 page write then immediate video access
        access(16'h0605, 1, 8'h3C); access(16'h0412, 0, 0); access(16'h0412, 1, 8'h99);
        access(16'h0605, 0, 0);
        // R8 top write with overlay on, then read after write (R10)
        access(16'hFE10, 1, 8'h77); access(16'hFE10, 0, 0);
        // R6 unused offset ignores writes
        access(16'h0610, 1, 8'hFF); access(16'h0610, 0, 0);
        access(16'h0602, 0, 0); access(16'h0605, 0, 0);
        // R9 overlay off, on, and other bits kept
        access(16'h0602, 1, 8'h00); access(16'hFE00, 0, 0); access(16'hFE00, 1, 8'h12);
        access(16'h0602, 1, 8'h08); access(16'hFE00, 0, 0);
        access(16'h0602, 1, 8'hF7); access(16'h0602, 0, 0); access(16'hFFF0, 0, 0);
        access(16'h0602, 1, 8'h08);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            int r;
            r = int'($urandom % 8);
            case (r)
                0: a = 16'h0600 + 16'($urandom % 24);
                1: a = {8'h04, 8'($urandom)};
                2: a = {8'h05, 8'($urandom)};
                3: a = 16'hFE00 + 16'($urandom % 512);
                4: a = ($urandom % 2 == 0) ? 16'h0602 : 16'h0605;
                default: a = 16'($urandom);
            endcase
            access(a, ($urandom % 3) == 0, 8'($urandom));
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule